// File: doc/BRIEF.md
# Strobe/Acknowledge Handshake Link

This block moves data words from a producer to a consumer over a three-part link: a data bus, a strobe wire driven by the sending side and an acknowledge wire driven by the receiving side. The sending engine takes words from a valid/ready source. It places each word on the bus and signals it on the strobe. Then it waits for the acknowledge before it takes the next word. The receiving engine captures the word into a one-entry output register, offers it on a valid/ready sink and answers on the acknowledge wire. Each control wire passes through a two-flop synchronizer before the far side reads it, so the two sides can sit in separate clock domains. The data bus itself is not synchronized. It is held steady for the whole exchange instead.

One engine handles two signalling disciplines. In level mode every transfer is a full return-to-zero cycle: strobe up, acknowledge up, strobe down, acknowledge down. In toggle mode each transfer flips the strobe once and is answered by one flip of the acknowledge. The sender may start the next word as soon as it sees that flip. The requested mode is adopted only while the whole link is quiet, so a transfer never changes discipline halfway through.

Top module: `hs_link`

## Requirements
- R1: After reset, bus_strobe and bus_ack are 0, snk_valid is 0, src_ready is 1 and mode_now is 0 (level mode).
- R2: While a transfer is outstanding (level: strobe held high; toggle: strobe differs from acknowledge), bus_data does not change.
- R3: In level mode (mode_now = 0), bus_ack rises only when the receiver holds the captured word (snk_valid = 1), and it stays low while the output register is full and cannot take the word.
- R4: In level mode, bus_strobe falls only while bus_ack is high, and bus_ack falls only while bus_strobe is low. Each word therefore causes two strobe transitions.
- R5: In toggle mode (mode_now = 1), each word causes exactly one strobe transition and one acknowledge transition, with no return to zero.
- R6: In toggle mode the sender accepts the next word as soon as the synchronized acknowledge equals the strobe, so a burst takes fewer cycles than in level mode.
- R7: src_ready is 1 only when the link is idle: in level mode both wires are low; in toggle mode bus_strobe equals bus_ack.
- R8: mode_req (0 = level, 1 = toggle) is copied to mode_now only when bus_strobe, bus_ack, both synchronized copies and snk_valid are all 0. Otherwise the change waits.
- R9: Every accepted word is delivered on the sink exactly once and in acceptance order, in both modes.
- R10: While snk_valid is 1 and snk_ready is 0, snk_valid stays 1 and snk_data stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 1 | Requested mode: 0 level, 1 toggle |
| src_valid | input | 1 | Producer has a word |
| src_data | input | DATA_W | Producer word |
| src_ready | output | 1 | Sender idle, word taken on this edge if valid |
| snk_valid | output | 1 | Receiver holds a word |
| snk_data | output | DATA_W | Word offered to the consumer |
| snk_ready | input | 1 | Consumer takes the word |
| mode_now | output | 1 | Mode in force |
| bus_strobe | output | 1 | Strobe wire as driven by the sender |
| bus_ack | output | 1 | Acknowledge wire as driven by the receiver |
| bus_data | output | DATA_W | Data bus as driven by the sender |

## Verification
The bound checker checks on every cycle the rules about wire ordering: data holding steady during a transfer, acknowledge rising only after capture, the order of the two falling edges in level mode, src_ready appearing only at idle, a mode change happening only on a quiet link, and the sink holding its word under backpressure. Some behaviour only shows across a whole transfer, so the bench scenarios cover it. These are delivery of each word exactly once and in order, the number of strobe transitions per word in each mode, the faster turnaround of toggle mode, and a mode request that waits while the wires rest high after an odd toggle-mode count.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic {
    MODE_LEVEL  = 1'b0,
    MODE_TOGGLE = 1'b1
  } hs_mode_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q, sr_n;

  always_comb begin
    sr_n = {sr_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_n;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/hs_tx.sv
module hs_tx
  import hs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hs_mode_e          mode,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              ack_s,
  output logic              strobe,
  output logic [DATA_W-1:0] data
);
  logic              strobe_q, strobe_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              idle, accept, release_bus, upd_en;

  always_comb begin
    if (mode == MODE_TOGGLE) idle = (strobe_q == ack_s);
    else                     idle = !strobe_q && !ack_s;
    accept      = src_valid && idle;
    release_bus = (mode == MODE_LEVEL) && strobe_q && ack_s;
    upd_en      = accept || release_bus;
    strobe_n    = strobe_q;
    data_n      = data_q;
    if (accept) begin
      data_n   = src_data;
      strobe_n = (mode == MODE_TOGGLE) ? !strobe_q : 1'b1;
    end else if (release_bus) begin
      data_n   = '0;
      strobe_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      data_q   <= '0;
    end else if (upd_en) begin
      strobe_q <= strobe_n;
      data_q   <= data_n;
    end
  end

  assign src_ready = idle;
  assign strobe    = strobe_q;
  assign data      = data_q;
endmodule

// File: rtl/hs_rx.sv
module hs_rx
  import hs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hs_mode_e          mode,
  input  logic              strobe_s,
  input  logic [DATA_W-1:0] bus_data,
  output logic              ack,
  output logic              snk_valid,
  output logic [DATA_W-1:0] snk_data,
  input  logic              snk_ready
);
  logic              ack_q, ack_n;
  logic              vld_q, vld_n;
  logic [DATA_W-1:0] dat_q, dat_n;
  logic              room, pending, capture, release_ack;

  always_comb begin
    room = !vld_q || snk_ready;
    if (mode == MODE_TOGGLE) pending = (strobe_s != ack_q);
    else                     pending = strobe_s && !ack_q;
    capture     = pending && room;
    release_ack = (mode == MODE_LEVEL) && !strobe_s && ack_q;
    ack_n = ack_q;
    if (capture)          ack_n = (mode == MODE_TOGGLE) ? !ack_q : 1'b1;
    else if (release_ack) ack_n = 1'b0;
    vld_n = capture ? 1'b1 : (snk_ready ? 1'b0 : vld_q);
    dat_n = capture ? bus_data : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      ack_q <= ack_n;
      vld_q <= vld_n;
      if (capture) dat_q <= dat_n;
    end
  end

  assign ack       = ack_q;
  assign snk_valid = vld_q;
  assign snk_data  = dat_q;
endmodule

// File: rtl/hs_link.sv
module hs_link
  import hs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_req,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              snk_valid,
  output logic [DATA_W-1:0] snk_data,
  input  logic              snk_ready,
  output logic              mode_now,
  output logic              bus_strobe,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_data
);
  hs_mode_e mode_q, mode_n;
  logic     strobe_s, ack_s, quiet;

  always_comb begin
    quiet  = !bus_strobe && !bus_ack && !strobe_s && !ack_s && !snk_valid;
    mode_n = hs_mode_e'(mode_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= MODE_LEVEL;
    else if (quiet) mode_q <= mode_n;
  end

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync_strobe (
    .clk(clk), .rst_n(rst_n), .d(bus_strobe), .q(strobe_s)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
    .clk(clk), .rst_n(rst_n), .d(bus_ack), .q(ack_s)
  );

  hs_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode_q),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .ack_s(ack_s), .strobe(bus_strobe), .data(bus_data)
  );

  hs_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .mode(mode_q),
    .strobe_s(strobe_s), .bus_data(bus_data), .ack(bus_ack),
    .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready)
  );

  assign mode_now = mode_q;
endmodule

// File: rtl/hs_link_chk.sv
module hs_link_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_ready,
  input logic              snk_valid,
  input logic [DATA_W-1:0] snk_data,
  input logic              snk_ready,
  input logic              mode_now,
  input logic              bus_strobe,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_data
);
  p_data_hold_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_now && bus_strobe && $past(bus_strobe)) |-> $stable(bus_data));

  p_data_hold_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now && $past(mode_now) && (bus_strobe != bus_ack) && $stable(bus_strobe))
      |-> $stable(bus_data));

  p_ack_after_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_now && $rose(bus_ack)) |-> snk_valid);

  p_strobe_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_now && $fell(bus_strobe)) |-> bus_ack);

  p_ack_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_now && $fell(bus_ack)) |-> !bus_strobe);

  p_ready_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && !mode_now) |-> (!bus_strobe && !bus_ack));

  p_ready_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ready && mode_now) |-> (bus_strobe == bus_ack));

  p_mode_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now != $past(mode_now)) |-> $past(!bus_strobe && !bus_ack && !snk_valid));

  p_sink_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data)));
endmodule

bind hs_link hs_link_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_ready(src_ready), .snk_valid(snk_valid),
  .snk_data(snk_data), .snk_ready(snk_ready), .mode_now(mode_now),
  .bus_strobe(bus_strobe), .bus_ack(bus_ack), .bus_data(bus_data)
);

// File: tb/tb_hs_link.sv
module tb_hs_link;
  localparam int DW = 8;

  logic          clk, rst_n, mode_req, src_valid, snk_ready, sink_en;
  logic [DW-1:0] src_data;
  logic          src_ready, snk_valid, mode_now, bus_strobe, bus_ack;
  logic [DW-1:0] snk_data, bus_data;

  int tests, fails, cyc, tx_cnt, rx_cnt, edges;
  logic          prev_strobe;
  logic [DW-1:0] exp_log [0:63];
  logic [DW-1:0] rx_log  [0:63];

  assign snk_ready = sink_en;

  hs_link #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready),
    .mode_now(mode_now), .bus_strobe(bus_strobe), .bus_ack(bus_ack),
    .bus_data(bus_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && snk_valid && snk_ready) begin
      if (rx_cnt < 64) rx_log[rx_cnt] = snk_data;
      rx_cnt = rx_cnt + 1;
    end
    if (rst_n && bus_strobe != prev_strobe) edges = edges + 1;
    prev_strobe = bus_strobe;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] w);
    src_data  = w;
    src_valid = 1'b1;
    while (!src_ready) @(negedge clk);
    @(negedge clk);
    src_valid = 1'b0;
    exp_log[tx_cnt] = w;
    tx_cnt = tx_cnt + 1;
  endtask

  task automatic wait_rx(input string req);
    int n = 0;
    while (rx_cnt < tx_cnt && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (12) @(negedge clk);
    check(rx_cnt == tx_cnt, req, rx_cnt, tx_cnt);
    for (int i = 0; i < tx_cnt; i++)
      if (rx_log[i] !== exp_log[i]) check(1'b0, req, rx_log[i], exp_log[i]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode_req = 1'b0; src_valid = 1'b0; src_data = '0; sink_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_strobe && !bus_ack, "R1 wires", {bus_strobe, bus_ack}, 0);
    check(!snk_valid, "R1 snk_valid", snk_valid, 0);
    check(src_ready, "R1 src_ready", src_ready, 1);
    check(!mode_now, "R1 mode", mode_now, 0);
  endtask

  task automatic burst(input int n, input logic [DW-1:0] base, output int cycles);
    int t0 = cyc;
    for (int i = 0; i < n; i++) push(base + DW'(i));
    wait_rx("R9 order");
    cycles = cyc - t0;
  endtask

  task automatic t_level_burst(output int cycles);
    edges = 0;
    burst(8, 8'h10, cycles);
    check(edges == 16, "R4 two strobe edges per word", edges, 16);
    check(!bus_strobe && !bus_ack, "R4 return to zero", {bus_strobe, bus_ack}, 0);
  endtask

  task automatic t_switch_toggle();
    mode_req = 1'b1;
    repeat (3) @(negedge clk);
    check(mode_now, "R8 switch when quiet", mode_now, 1);
  endtask

  task automatic t_toggle_burst(output int cycles);
    edges = 0;
    burst(8, 8'h40, cycles);
    check(edges == 8, "R5 one strobe edge per word", edges, 8);
    check(bus_strobe == bus_ack, "R5 wires equal at rest", bus_ack, bus_strobe);
  endtask

  task automatic t_toggle_backpressure();
    sink_en = 1'b0;
    push(8'hA1);
    push(8'hA2);
    repeat (20) @(negedge clk);
    check(snk_valid && snk_data == 8'hA1, "R10 toggle hold", snk_data, 8'hA1);
    check(bus_strobe != bus_ack, "R2 second word pending", bus_ack, !bus_strobe);
    check(bus_data == 8'hA2, "R2 bus holds word", bus_data, 8'hA2);
    sink_en = 1'b1;
    wait_rx("R9 after toggle stall");
  endtask

  task automatic t_deferred_switch();
    push(8'hC3);
    repeat (12) @(negedge clk);
    mode_req = 1'b0;
    repeat (10) @(negedge clk);
    check(mode_now, "R8 deferred while wires high", mode_now, 1);
    check(bus_strobe && bus_ack, "R5 no return to zero", {bus_strobe, bus_ack}, 3);
    push(8'hC4);
    wait_rx("R9 across switch");
    check(!mode_now, "R8 switch after wires low", mode_now, 0);
  endtask

  task automatic t_level_backpressure();
    sink_en = 1'b0;
    push(8'h5A);
    push(8'h5B);
    repeat (20) @(negedge clk);
    check(bus_strobe && !bus_ack, "R3 no ack without capture", {bus_strobe, bus_ack}, 2);
    check(snk_valid && snk_data == 8'h5A, "R10 level hold", snk_data, 8'h5A);
    check(!src_ready, "R7 busy not ready", src_ready, 0);
    sink_en = 1'b1;
    wait_rx("R9 after level stall");
  endtask

  initial begin
    int lvl_cyc, tgl_cyc;
    tests = 0; fails = 0; cyc = 0; tx_cnt = 0; rx_cnt = 0; edges = 0;
    prev_strobe = 1'b0;
    t_reset();
    t_level_burst(lvl_cyc);
    t_switch_toggle();
    t_toggle_burst(tgl_cyc);
    check(tgl_cyc < lvl_cyc, "R6 toggle burst faster", tgl_cyc, lvl_cyc);
    t_toggle_backpressure();
    t_deferred_switch();
    t_level_backpressure();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule